// File: doc/BRIEF.md
# Single-Wire Half-Duplex UART Transceiver

This block sends and receives bytes over one open-drain data wire that is shared by both directions and pulled high by an external resistor. It never drives the wire high. It either pulls it low or lets it go. A frame is a low start bit, eight data bits least significant first, one odd-parity bit, and two high stop bits. Every bit lasts sixteen ticks of an internal oversampling clock. The tick rate comes from a speed code. The clock-to-tick divisors are computed when the design is elaborated from the `CLK_HZ` parameter.

Because the wire is shared, every frame the block sends also comes back into its own receiver. The receiver still decodes that echo, then throws it away, so only frames from the far end reach the receive interface. Received bytes wait in a one-byte holding register with valid/ready handshaking. The register carries a parity-error flag and a framing-error flag. A flush input empties it. The transmit side accepts a byte only when the wire is free in both directions.

Top module: `sw_uart`

## Requirements
- R1: A transmitted frame is, in order: start bit 0; data bits 0 to 7; the odd-parity bit, which makes the total count of ones in data plus parity odd; then two stop bits at 1. A 0 on the wire means `lineDriveLow`=1, and a 1 means it is released.
- R2: Speed codes 0 to 5 select 460800, 230400, 115200, 57600, 38400 and 19200 baud. One bit lasts 16·round(CLK_HZ/(16·baud)) clock cycles. Codes 6 and 7 use the rate of code `DEFAULT_SPEED`, which defaults to 1 (230400 baud).
- R3: `lineDriveLow` is 1 only while a transmit frame is in progress, which is also while `txReady` is 0.
- R4: A frame the block sends itself, received back through `lineIn`, never raises `rxValid`.
- R5: A frame from the far end is delivered on `rxData` with `rxValid`=1. Both hold until `rxReady`=1 is seen on a clock edge.
- R6: A received frame whose parity bit does not give odd parity is delivered with `rxParityErr`=1. Otherwise `rxParityErr` is 0.
- R7: A received frame with a low level in the first or the second stop-bit position is delivered with `rxFrameErr`=1. Otherwise `rxFrameErr` is 0.
- R8: A low pulse on the wire shorter than half a bit is not taken as a start bit. No byte is delivered, and the receiver is idle again afterwards.
- R9: `rxFlush`=1 discards the byte in the holding register. Later frames are delivered normally.
- R10: A frame that completes while an earlier byte is still unread replaces that byte.
- R11: `txReady` is 0 from the edge that accepts a byte until the last stop bit ends, and also while a frame from the far end is being received.
- R12: After reset `txReady`=1, `rxValid`=0 and `lineDriveLow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedSel | input | 3 | Baud-rate code |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte to send is present |
| txReady | output | 1 | Transmitter will accept a byte on this edge |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Holding register is full |
| rxReady | input | 1 | Consumer takes the held byte |
| rxFlush | input | 1 | Discard the held byte |
| rxParityErr | output | 1 | Held byte failed the odd-parity check |
| rxFrameErr | output | 1 | Held byte had a low stop bit |
| lineIn | input | 1 | Level of the shared wire |
| lineDriveLow | output | 1 | Pull the shared wire low when 1 |

## Verification
The hardest state to reach from the ports is a receiver that is busy with its own echo while a byte from the far end sits unread in the holding register. Only the hidden echo flag keeps the echo from overwriting that byte. The bench sets this up by letting a peer frame arrive, leaving it unconsumed, and then sending a byte of its own. A reference model, checked on every clock, demands that `rxValid` and the held byte stay exactly as the model says. Broken frames come from the same peer driver on the modelled wire: it inverts the parity bit, or pulls one stop bit low, or drops the wire for a quarter of a bit so the start-bit check must reject it.

// File: rtl/sw_uart_pkg.sv
package sw_uart_pkg;

  localparam int DATA_BITS = 8;
  // start + data + parity + two stop bits
  localparam int TX_BITS = DATA_BITS + 4;
  // receiver samples data, parity and both stop bits
  localparam int RX_BITS = DATA_BITS + 3;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS_ST,
    RX_DONE
  } rxState_t;

  typedef struct packed {
    logic txLoad;    // capture a new byte into the frame shifter
    logic txShift;   // move to the next frame bit
    logic txActive;  // a frame is on the wire
    logic rxSample;  // capture the synchronized line level
    logic rxCommit;  // move the assembled byte into the holding register
  } swuStrobe_t;

  function automatic int rateOfCode(input int code);
    case (code)
      0: return 460800;
      1: return 230400;
      2: return 115200;
      3: return 57600;
      4: return 38400;
      5: return 19200;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/swu_baud.sv
module swu_baud
  import sw_uart_pkg::*;
#(
  parameter int CLK_HZ        = 250_000_000,
  parameter int OVERSAMPLE    = 16,
  parameter int DEFAULT_SPEED = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] speedSel,
  output logic       tick
);

  localparam int DIV_W = $clog2(CLK_HZ / (OVERSAMPLE * 19200) + 2);

  typedef logic [7:0][DIV_W-1:0] divTable_t;

  function automatic divTable_t buildTable();
    divTable_t t;
    for (int c = 0; c < 8; c++) begin
      int r;
      int d;
      r = rateOfCode(c);
      if (r == 0) r = rateOfCode(DEFAULT_SPEED);
      d = (CLK_HZ + (OVERSAMPLE / 2) * r) / (OVERSAMPLE * r);
      if (d < 1) d = 1;
      t[c] = DIV_W'(d);
    end
    return t;
  endfunction

  localparam divTable_t DIVS = buildTable();

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= DIVS[DEFAULT_SPEED];
      cnt    <= '0;
      tick   <= 1'b0;
    end else begin
      divReg <= DIVS[speedSel];
      if (cnt >= divReg - 1'b1) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/swu_ctrl.sv
module swu_ctrl
  import sw_uart_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       txValid,
  input  logic       lineLvl,
  input  logic       lineFall,
  output logic       txReady,
  output swuStrobe_t strb
);

  localparam int TW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(TX_BITS);
  localparam logic [TW-1:0] TICK_LAST = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] TICK_MID  = TW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] TX_LAST   = BW'(TX_BITS - 1);
  localparam logic [BW-1:0] RX_LAST   = BW'(RX_BITS - 1);

  // transmit sequencing
  logic          txActive;
  logic [TW-1:0] txTickCnt;
  logic [BW-1:0] txBitIdx;
  logic          txAccept;
  logic          txBitEnd;

  // receive sequencing
  rxState_t      rxState;
  logic [TW-1:0] rxTickCnt;
  logic [BW-1:0] rxBitIdx;
  logic          echoFrame;

  assign txReady  = !txActive && (rxState == RX_IDLE);
  assign txAccept = txValid && txReady;
  assign txBitEnd = txActive && tick && (txTickCnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive  <= 1'b0;
      txTickCnt <= '0;
      txBitIdx  <= '0;
    end else if (txAccept) begin
      txActive  <= 1'b1;
      txTickCnt <= '0;
      txBitIdx  <= '0;
    end else if (txActive && tick) begin
      if (txTickCnt == TICK_LAST) begin
        txTickCnt <= '0;
        if (txBitIdx == TX_LAST) txActive <= 1'b0;
        else txBitIdx <= txBitIdx + 1'b1;
      end else begin
        txTickCnt <= txTickCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState   <= RX_IDLE;
      rxTickCnt <= '0;
      rxBitIdx  <= '0;
      echoFrame <= 1'b0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (lineFall) begin
            rxState   <= RX_START;
            rxTickCnt <= '0;
            echoFrame <= txActive;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxTickCnt == TICK_MID) begin
              rxTickCnt <= '0;
              rxBitIdx  <= '0;
              rxState   <= lineLvl ? RX_IDLE : RX_BITS_ST;
            end else begin
              rxTickCnt <= rxTickCnt + 1'b1;
            end
          end
        end
        RX_BITS_ST: begin
          if (tick) begin
            if (rxTickCnt == TICK_LAST) begin
              rxTickCnt <= '0;
              if (rxBitIdx == RX_LAST) rxState <= RX_DONE;
              else rxBitIdx <= rxBitIdx + 1'b1;
            end else begin
              rxTickCnt <= rxTickCnt + 1'b1;
            end
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.txLoad   = txAccept;
    strb.txShift  = txBitEnd;
    strb.txActive = txActive;
    strb.rxSample = (rxState == RX_BITS_ST) && tick && (rxTickCnt == TICK_LAST);
    strb.rxCommit = (rxState == RX_DONE) && !echoFrame;
  end

endmodule

// File: rtl/swu_dpath.sv
module swu_dpath
  import sw_uart_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swuStrobe_t           strb,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 lineIn,
  input  logic                 rxReady,
  input  logic                 rxFlush,
  output logic                 lineLvl,
  output logic                 lineFall,
  output logic                 lineDriveLow,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 rxParityErr,
  output logic                 rxFrameErr
);

  logic [SYNC_STAGES:0] syncQ;
  logic [TX_BITS-1:0]   txFrame;
  logic [RX_BITS-1:0]   rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else syncQ <= {syncQ[SYNC_STAGES-1:0], lineIn};
  end

  assign lineLvl  = syncQ[SYNC_STAGES-1];
  assign lineFall = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1];

  // frame shifter: bit 0 is the bit on the wire
  always_ff @(posedge clk) begin
    if (!rstN) txFrame <= '1;
    else if (strb.txLoad) txFrame <= {2'b11, ~^txData, txData, 1'b0};
    else if (strb.txShift) txFrame <= {1'b1, txFrame[TX_BITS-1:1]};
  end

  assign lineDriveLow = strb.txActive & ~txFrame[0];

  always_ff @(posedge clk) begin
    if (!rstN) rxShift <= '1;
    else if (strb.rxSample) rxShift <= {lineLvl, rxShift[RX_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end else if (strb.rxCommit) begin
      rxData      <= rxShift[DATA_BITS-1:0];
      rxValid     <= 1'b1;
      rxParityErr <= ~(^rxShift[DATA_BITS:0]);
      rxFrameErr  <= ~(rxShift[DATA_BITS+1] & rxShift[DATA_BITS+2]);
    end else if (rxValid && (rxReady || rxFlush)) begin
      rxValid <= 1'b0;
    end
  end

endmodule

// File: rtl/sw_uart.sv
module sw_uart
  import sw_uart_pkg::*;
#(
  parameter int CLK_HZ        = 250_000_000,
  parameter int DEFAULT_SPEED = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] speedSel,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  input  logic       rxFlush,
  output logic       rxParityErr,
  output logic       rxFrameErr,
  input  logic       lineIn,
  output logic       lineDriveLow
);

  localparam int OVERSAMPLE = 16;

  logic       tick;
  logic       lineLvl;
  logic       lineFall;
  swuStrobe_t strb;

  swu_baud #(
    .CLK_HZ       (CLK_HZ),
    .OVERSAMPLE   (OVERSAMPLE),
    .DEFAULT_SPEED(DEFAULT_SPEED)
  ) u_baud (
    .clk     (clk),
    .rstN    (rstN),
    .speedSel(speedSel),
    .tick    (tick)
  );

  swu_ctrl #(
    .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .txValid (txValid),
    .lineLvl (lineLvl),
    .lineFall(lineFall),
    .txReady (txReady),
    .strb    (strb)
  );

  swu_dpath #(
    .SYNC_STAGES(2)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .txData      (txData),
    .lineIn      (lineIn),
    .rxReady     (rxReady),
    .rxFlush     (rxFlush),
    .lineLvl     (lineLvl),
    .lineFall    (lineFall),
    .lineDriveLow(lineDriveLow),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr)
  );

endmodule

// File: rtl/sw_uart_chk.sv
module sw_uart_chk
  import sw_uart_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       rxReady,
  input logic       rxFlush,
  input logic       lineDriveLow,
  input swuStrobe_t strb
);

  // R3: pulling the wire low only happens inside a transmit frame
  a_r3_drive_only_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> !txReady);

  // R1: the wire level changes only at a load or a bit boundary
  a_r1_level_moves_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.txLoad && !strb.txShift) |=> $stable(lineDriveLow));

  // R4: the receiver never commits while this side is on the wire
  a_r4_no_commit_while_sending: assert property (@(posedge clk) disable iff (!rstN)
    strb.txActive |-> !strb.rxCommit);

  // R5: a held byte stays until taken
  a_r5_valid_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !rxFlush) |=> rxValid);

  // R5: held data does not change while waiting
  a_r5_data_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !rxFlush && !strb.rxCommit) |=> $stable(rxData));

  // R9: flush empties the holding register
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFlush && !strb.rxCommit) |=> !rxValid);

  // R11: an accepted byte blocks further acceptance
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

endmodule

bind sw_uart sw_uart_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txValid     (txValid),
  .txReady     (txReady),
  .rxData      (rxData),
  .rxValid     (rxValid),
  .rxReady     (rxReady),
  .rxFlush     (rxFlush),
  .lineDriveLow(lineDriveLow),
  .strb        (strb)
);

// File: tb/sw_uart_tb.sv
`timescale 1ns/1ps
module sw_uart_tb;

  localparam int CLK_HZ = 29_491_200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] speedSel = 3'd1;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxReady = 1'b0;
  logic       rxFlush = 1'b0;
  logic       rxParityErr;
  logic       rxFrameErr;
  logic       lineIn;
  logic       lineDriveLow;
  logic       peerLow = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  bit       peerBusy = 1'b0;
  bit       dutBusy = 1'b0;
  bit       modelHas = 1'b0;
  bit [7:0] modelData = 8'h00;
  bit       modelPar = 1'b0;
  bit       modelFrm = 1'b0;

  always #2 clk = ~clk;

  assign lineIn = ~(lineDriveLow | peerLow);

  sw_uart #(.CLK_HZ(CLK_HZ), .DEFAULT_SPEED(1)) u_dut (
    .clk(clk), .rstN(rstN), .speedSel(speedSel),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .rxFlush(rxFlush),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .lineIn(lineIn), .lineDriveLow(lineDriveLow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int divFor(input int code);
    int r;
    case (code)
      0: r = 460800;
      1: r = 230400;
      2: r = 115200;
      3: r = 57600;
      4: r = 38400;
      5: r = 19200;
      default: r = 230400;
    endcase
    return (CLK_HZ + 8 * r) / (16 * r);
  endfunction

  function automatic bit frameBit(input bit [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return ~^d;
    return 1'b1;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // cycle counter and watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finishRun();
    end
  end

  // per-clock comparison against the model
  always begin
    @(posedge clk);
    #2;
    if (rstN && !peerBusy) begin
      checks++;
      if (rxValid !== modelHas) begin
        failures++;
        $display("FAIL R4/R10 rxValid actual=%0d expected=%0d", rxValid, modelHas);
      end
    end
    if (rstN && !dutBusy) begin
      checks++;
      if (lineDriveLow !== 1'b0) begin
        failures++;
        $display("FAIL R3 lineDriveLow outside frame actual=%0d expected=0", lineDriveLow);
      end
    end
  end

  task automatic setSpeed(input int code);
    @(negedge clk);
    speedSel = 3'(code);
    repeat (4) @(negedge clk);
  endtask

  task automatic dutSend(input bit [7:0] d, input int code);
    int div;
    int bitLen;
    int startCyc;
    int dur;
    div = divFor(code);
    bitLen = 16 * div;
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = d;
    txValid = 1'b1;
    dutBusy = 1'b1;
    @(posedge clk);
    startCyc = cyc;
    #1;
    txValid = 1'b0;
    check(txReady == 1'b0, "R11 ready after accept", int'(txReady), 0);
    repeat (bitLen / 2) @(posedge clk);
    for (int k = 0; k < 12; k++) begin
      if (k > 0) repeat (bitLen) @(posedge clk);
      #1;
      check((!lineDriveLow) == frameBit(d, k), "R1 frame bit", int'(!lineDriveLow),
            int'(frameBit(d, k)));
    end
    while (!txReady) begin
      @(posedge clk);
      #1;
    end
    dur = cyc - startCyc;
    check(dur >= 12 * bitLen - div && dur <= 12 * bitLen, "R2 frame length", dur, 12 * bitLen);
    dutBusy = 1'b0;
  endtask

  task automatic peerSend(input bit [7:0] d, input bit badPar, input bit badS1,
                          input bit badS2, input int code);
    int bitLen;
    bit b;
    bitLen = 16 * divFor(code);
    @(negedge clk);
    peerBusy = 1'b1;
    for (int k = 0; k < 12; k++) begin
      b = frameBit(d, k);
      if (k == 9 && badPar) b = ~b;
      if (k == 10 && badS1) b = 1'b0;
      if (k == 11 && badS2) b = 1'b0;
      peerLow = ~b;
      if (k == 5) begin
        repeat (bitLen / 2) @(negedge clk);
        check(txReady == 1'b0, "R11 ready during peer frame", int'(txReady), 0);
        repeat (bitLen - bitLen / 2) @(negedge clk);
      end else begin
        repeat (bitLen) @(negedge clk);
      end
    end
    peerLow = 1'b0;
    modelHas = 1'b1;
    modelData = d;
    modelPar = badPar;
    modelFrm = badS1 | badS2;
    peerBusy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic consume(input string tag);
    @(negedge clk);
    check(rxValid == 1'b1, {tag, " R5 valid"}, int'(rxValid), 1);
    check(rxData == modelData, {tag, " R5 data"}, int'(rxData), int'(modelData));
    check(rxParityErr == modelPar, {tag, " R6 parity flag"}, int'(rxParityErr), int'(modelPar));
    check(rxFrameErr == modelFrm, {tag, " R7 frame flag"}, int'(rxFrameErr), int'(modelFrm));
    rxReady = 1'b1;
    @(posedge clk);
    #1;
    modelHas = 1'b0;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(txReady == 1'b1, "R12 txReady", int'(txReady), 1);
    check(rxValid == 1'b0, "R12 rxValid", int'(rxValid), 0);
    check(lineDriveLow == 1'b0, "R12 lineDriveLow", int'(lineDriveLow), 0);

    // R1, R2, R3, R4: own frames at several speeds, echoes must vanish
    dutSend(8'hA5, 1);
    setSpeed(0);
    dutSend(8'h3C, 0);
    dutSend(8'h00, 0);
    dutSend(8'hFF, 0);
    setSpeed(5);
    dutSend(8'h5A, 5);
    setSpeed(6);
    dutSend(8'h81, 6);   // R2 fallback code
    setSpeed(7);
    dutSend(8'h18, 7);   // R2 fallback code

    // R5, R6, R7: peer frames, clean and broken
    setSpeed(1);
    peerSend(8'h96, 1'b0, 1'b0, 1'b0, 1);
    consume("clean");
    peerSend(8'h4B, 1'b1, 1'b0, 1'b0, 1);
    consume("R6 bad parity");
    peerSend(8'hC3, 1'b0, 1'b1, 1'b0, 1);
    consume("R7 low stop1");
    peerSend(8'h2D, 1'b0, 1'b0, 1'b1, 1);
    consume("R7 low stop2");

    // R10: unread byte replaced
    peerSend(8'h11, 1'b0, 1'b0, 1'b0, 1);
    peerSend(8'hE7, 1'b0, 1'b0, 1'b0, 1);
    consume("R10 overwrite");

    // R4: echo while a peer byte is held must not disturb it
    peerSend(8'h6E, 1'b0, 1'b0, 1'b0, 1);
    dutSend(8'h99, 1);
    consume("R4 held across echo");

    // R9: flush then a fresh byte
    peerSend(8'h72, 1'b0, 1'b0, 1'b0, 1);
    @(negedge clk);
    rxFlush = 1'b1;
    @(posedge clk);
    #1;
    modelHas = 1'b0;
    @(negedge clk);
    rxFlush = 1'b0;
    check(rxValid == 1'b0, "R9 flushed", int'(rxValid), 0);
    peerSend(8'h0F, 1'b0, 1'b0, 1'b0, 1);
    consume("R9 after flush");

    // R8: short low pulse rejected
    begin
      int bitLen;
      bitLen = 16 * divFor(1);
      @(negedge clk);
      peerBusy = 1'b1;
      peerLow = 1'b1;
      repeat (bitLen / 4) @(negedge clk);
      peerLow = 1'b0;
      repeat (bitLen) @(negedge clk);
      peerBusy = 1'b0;
      repeat (13 * bitLen) @(negedge clk);
      check(rxValid == 1'b0, "R8 no byte from glitch", int'(rxValid), 0);
      check(txReady == 1'b1, "R8 receiver idle", int'(txReady), 1);
    end

    // slower peer rate, then turnaround
    setSpeed(4);
    peerSend(8'h7E, 1'b0, 1'b0, 1'b0, 4);
    consume("R2 slow peer");
    dutSend(8'hC6, 4);

    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule